// File: doc/BRIEF.md
# Circular-Buffer Address Pointer Unit

This block supplies read and write addresses to a pair of small data RAMs, the kind that feed a multiply-accumulate pipeline. It keeps two address pointers. Each pointer has its own modulus register, and each of the four registers can be loaded from outside. On every access, one pointer is chosen. Its present value goes straight out as the RAM address. At the following clock edge the chosen pointer is then stepped according to a post-modify mode.

A step can do nothing, count up, count down, or count up or down inside the circular range 0 to N-1. Here N is the modulus paired with that pointer. Because of this, a filter loop can walk a ring buffer of samples or coefficients with no extra instructions to fix the pointer up. Instruction decoding and the RAMs sit outside the block.

Top module: `ptrAddrUnit`

## Requirements
- R1: After reset, both pointers and both moduli hold 0, so `addrOut` reads 0 for either pointer selection.
- R2: `addrOut` always shows the current value of the pointer chosen by `accSel` (0 = first pointer, 1 = second pointer). It shows that value before any modification, and a pointer changes only at a clock edge.
- R3: An access with `accMode` = 1 adds one to the chosen pointer, and 255 becomes 0.
- R4: An access with `accMode` = 2 subtracts one from the chosen pointer, and 0 becomes 255.
- R5: An access with `accMode` = 3 adds one to the chosen pointer, but a pointer equal to N-1 becomes 0. N is the modulus register with the same index as the pointer.
- R6: An access with `accMode` = 4 subtracts one from the chosen pointer, but a pointer equal to 0 becomes N-1.
- R7: When the paired modulus is 0, modes 3 and 4 behave exactly like modes 1 and 2, wrapping across the full 8-bit range.
- R8: When a pointer load and a post-modify hit the same pointer in the same cycle, the loaded value wins. A load to one pointer and a step of the other pointer in the same cycle both take effect.
- R9: Mode 0, the unused codes 5 to 7, and any cycle with `accEn` low leave both pointers unchanged.
- R10: A modulus load takes effect from the next cycle on. A modulo step in the same cycle as the load still uses the old modulus, and a modulus load never changes a pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| ldPtrEn | input | 1 | Load a pointer this cycle |
| ldPtrSel | input | 1 | Index of the pointer to load |
| ldPtrVal | input | 8 | Value to load into the pointer |
| ldModEn | input | 1 | Load a modulus register this cycle |
| ldModSel | input | 1 | Index of the modulus register to load |
| ldModVal | input | 8 | Value to load into the modulus register |
| accEn | input | 1 | Access strobe; enables the post-modify |
| accSel | input | 1 | Index of the pointer used for the access |
| accMode | input | 3 | Post-modify code: 0 hold, 1 up, 2 down, 3 circular up, 4 circular down, 5 to 7 hold |
| addrOut | output | 8 | RAM address: current value of the selected pointer |

## Verification
A wrong pointer value is visible on `addrOut` the very next cycle the bench selects that pointer. So every step, load and collision is checked one cycle after it happens, by reading the pointer through a hold-mode access.

A wrong modulus cannot be seen directly. It shows up only when a circular step reaches a wrap point, so the bench loads small moduli and places pointers next to their bounds. That way a bad limit produces a wrong address within a few accesses.

The random stream mixes loads into both registers with accesses in all eight mode codes, including same-cycle collisions. Every address is compared with a reference model in the bench.

// File: rtl/ptrAddrPkg.sv
package ptrAddrPkg;

  localparam int NUM_PTR = 2;
  localparam int SEL_W   = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1;

  // Post-modify codes as they appear on the access port
  typedef enum logic [2:0] {
    MODE_HOLD     = 3'd0,
    MODE_INC      = 3'd1,
    MODE_DEC      = 3'd2,
    MODE_INC_WRAP = 3'd3,
    MODE_DEC_WRAP = 3'd4
  } stepMode_t;

  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } stepDir_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic [NUM_PTR-1:0] ptrLd;
    logic [NUM_PTR-1:0] ptrUpd;
    logic [NUM_PTR-1:0] modLd;
    stepDir_t           dir;
    logic               wrapOn;
    logic [SEL_W-1:0]   rdSel;
  } strobe_t;

endpackage

// File: rtl/ptrAddrCtrl.sv
module ptrAddrCtrl
  import ptrAddrPkg::*;
(
  input  logic             ldPtrEn,
  input  logic [SEL_W-1:0] ldPtrSel,
  input  logic             ldModEn,
  input  logic [SEL_W-1:0] ldModSel,
  input  logic             accEn,
  input  logic [SEL_W-1:0] accSel,
  input  logic [2:0]       accMode,
  output strobe_t          strb
);

  stepDir_t stepDir;
  logic     stepWrap;

  // Mode decode: unknown codes fall back to hold
  always_comb begin
    stepDir  = DIR_NONE;
    stepWrap = 1'b0;
    case (accMode)
      MODE_INC:      begin stepDir = DIR_UP;   stepWrap = 1'b0; end
      MODE_DEC:      begin stepDir = DIR_DOWN; stepWrap = 1'b0; end
      MODE_INC_WRAP: begin stepDir = DIR_UP;   stepWrap = 1'b1; end
      MODE_DEC_WRAP: begin stepDir = DIR_DOWN; stepWrap = 1'b1; end
      default:       begin stepDir = DIR_NONE; stepWrap = 1'b0; end
    endcase
  end

  logic [NUM_PTR-1:0] ptrLdVec;
  logic [NUM_PTR-1:0] ptrUpdVec;
  logic [NUM_PTR-1:0] modLdVec;

  for (genvar k = 0; k < NUM_PTR; k++) begin : g_sel
    assign ptrLdVec[k]  = ldPtrEn && (ldPtrSel == SEL_W'(k));
    assign modLdVec[k]  = ldModEn && (ldModSel == SEL_W'(k));
    // a load to the same pointer overrides the step
    assign ptrUpdVec[k] = accEn && (accSel == SEL_W'(k)) &&
                          (stepDir != DIR_NONE) && !ptrLdVec[k];
  end

  always_comb begin
    strb.ptrLd  = ptrLdVec;
    strb.ptrUpd = ptrUpdVec;
    strb.modLd  = modLdVec;
    strb.dir    = stepDir;
    strb.wrapOn = stepWrap;
    strb.rdSel  = accSel;
  end

endmodule

// File: rtl/ptrAddrPath.sv
module ptrAddrPath
  import ptrAddrPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  strobe_t                          strb,
  input  logic [ADDR_W-1:0]                ldPtrVal,
  input  logic [ADDR_W-1:0]                ldModVal,
  output logic [ADDR_W-1:0]                addrOut,
  output logic [NUM_PTR-1:0][ADDR_W-1:0]   ptrView,
  output logic [NUM_PTR-1:0][ADDR_W-1:0]   modView
);

  localparam logic [ADDR_W-1:0] ZERO = '0;
  localparam logic [ADDR_W-1:0] ONE  = ADDR_W'(1);

  // Next pointer value; a zero modulus makes lim-1 all ones,
  // which is the same as a plain full-range wrap
  function automatic logic [ADDR_W-1:0] stepNext(
    input logic [ADDR_W-1:0] cur,
    input logic [ADDR_W-1:0] lim,
    input stepDir_t          dir,
    input logic              wrap
  );
    logic [ADDR_W-1:0] topVal;
    topVal = lim - ONE;
    case (dir)
      DIR_UP:   stepNext = (wrap && cur == topVal) ? ZERO : cur + ONE;
      DIR_DOWN: stepNext = (wrap && cur == ZERO) ? topVal : cur - ONE;
      default:  stepNext = cur;
    endcase
  endfunction

  logic [NUM_PTR-1:0][ADDR_W-1:0] ptrQ;
  logic [NUM_PTR-1:0][ADDR_W-1:0] modQ;

  for (genvar k = 0; k < NUM_PTR; k++) begin : g_reg
    logic [ADDR_W-1:0] stepVal;

    assign stepVal = stepNext(ptrQ[k], modQ[k], strb.dir, strb.wrapOn);

    always_ff @(posedge clk) begin
      if (!rstN)               ptrQ[k] <= '0;
      else if (strb.ptrLd[k])  ptrQ[k] <= ldPtrVal;
      else if (strb.ptrUpd[k]) ptrQ[k] <= stepVal;
    end

    always_ff @(posedge clk) begin
      if (!rstN)              modQ[k] <= '0;
      else if (strb.modLd[k]) modQ[k] <= ldModVal;
    end
  end

  assign addrOut = ptrQ[strb.rdSel];
  assign ptrView = ptrQ;
  assign modView = modQ;

endmodule

// File: rtl/ptrAddrUnit.sv
module ptrAddrUnit
  import ptrAddrPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ldPtrEn,
  input  logic [SEL_W-1:0]  ldPtrSel,
  input  logic [ADDR_W-1:0] ldPtrVal,
  input  logic              ldModEn,
  input  logic [SEL_W-1:0]  ldModSel,
  input  logic [ADDR_W-1:0] ldModVal,
  input  logic              accEn,
  input  logic [SEL_W-1:0]  accSel,
  input  logic [2:0]        accMode,
  output logic [ADDR_W-1:0] addrOut
);

  strobe_t                        strb;
  logic [NUM_PTR-1:0][ADDR_W-1:0] ptrView;
  logic [NUM_PTR-1:0][ADDR_W-1:0] modView;

  ptrAddrCtrl i_ctrl (
    .ldPtrEn  (ldPtrEn),
    .ldPtrSel (ldPtrSel),
    .ldModEn  (ldModEn),
    .ldModSel (ldModSel),
    .accEn    (accEn),
    .accSel   (accSel),
    .accMode  (accMode),
    .strb     (strb)
  );

  ptrAddrPath #(.ADDR_W(ADDR_W)) i_path (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .ldPtrVal (ldPtrVal),
    .ldModVal (ldModVal),
    .addrOut  (addrOut),
    .ptrView  (ptrView),
    .modView  (modView)
  );

endmodule

// File: rtl/ptrAddrCheck.sv
module ptrAddrCheck
  import ptrAddrPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           ldPtrEn,
  input logic [SEL_W-1:0]               ldPtrSel,
  input logic [ADDR_W-1:0]              ldPtrVal,
  input logic                           ldModEn,
  input logic [SEL_W-1:0]               ldModSel,
  input logic [ADDR_W-1:0]              ldModVal,
  input logic                           accEn,
  input logic [SEL_W-1:0]               accSel,
  input logic [2:0]                     accMode,
  input logic [NUM_PTR-1:0][ADDR_W-1:0] ptrView,
  input logic [NUM_PTR-1:0][ADDR_W-1:0] modView
);

  logic [ADDR_W-1:0] selPtr;
  logic [ADDR_W-1:0] selMod;
  logic [ADDR_W-1:0] selTop;
  logic              selLd;

  assign selPtr = ptrView[accSel];
  assign selMod = modView[accSel];
  assign selTop = selMod - ADDR_W'(1);
  assign selLd  = ldPtrEn && (ldPtrSel == accSel);

  a_r3_inc_step: assert property (@(posedge clk) disable iff (!rstN)
    accEn && accMode == 3'd1 && !selLd
    |=> ptrView[$past(accSel)] == ADDR_W'($past(selPtr) + ADDR_W'(1)));

  a_r4_dec_step: assert property (@(posedge clk) disable iff (!rstN)
    accEn && accMode == 3'd2 && !selLd
    |=> ptrView[$past(accSel)] == ADDR_W'($past(selPtr) - ADDR_W'(1)));

  a_r5_wrap_to_zero: assert property (@(posedge clk) disable iff (!rstN)
    accEn && accMode == 3'd3 && !selLd && selPtr == selTop
    |=> ptrView[$past(accSel)] == '0);

  a_r6_wrap_to_top: assert property (@(posedge clk) disable iff (!rstN)
    accEn && accMode == 3'd4 && !selLd && selPtr == '0
    |=> ptrView[$past(accSel)] == $past(selTop));

  a_r8_load_wins: assert property (@(posedge clk) disable iff (!rstN)
    ldPtrEn |=> ptrView[$past(ldPtrSel)] == $past(ldPtrVal));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ldPtrEn && (!accEn || accMode == 3'd0 || accMode > 3'd4)
    |=> $stable(ptrView));

  a_r10_mod_load: assert property (@(posedge clk) disable iff (!rstN)
    ldModEn |=> modView[$past(ldModSel)] == $past(ldModVal));

endmodule

bind ptrAddrUnit ptrAddrCheck #(.ADDR_W(ADDR_W)) i_check (
  .clk      (clk),
  .rstN     (rstN),
  .ldPtrEn  (ldPtrEn),
  .ldPtrSel (ldPtrSel),
  .ldPtrVal (ldPtrVal),
  .ldModEn  (ldModEn),
  .ldModSel (ldModSel),
  .ldModVal (ldModVal),
  .accEn    (accEn),
  .accSel   (accSel),
  .accMode  (accMode),
  .ptrView  (ptrView),
  .modView  (modView)
);

// File: tb/test_ptrAddrUnit.sv
module test_ptrAddrUnit;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ldPtrEn = 1'b0;
  logic [0:0] ldPtrSel = '0;
  logic [7:0] ldPtrVal = '0;
  logic       ldModEn = 1'b0;
  logic [0:0] ldModSel = '0;
  logic [7:0] ldModVal = '0;
  logic       accEn = 1'b0;
  logic [0:0] accSel = '0;
  logic [2:0] accMode = '0;
  logic [7:0] addrOut;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [7:0] mPtr [2];
  logic [7:0] mMod [2];

  always #5 clk = ~clk;

  ptrAddrUnit i_ptrAddrUnit (
    .clk(clk), .rstN(rstN),
    .ldPtrEn(ldPtrEn), .ldPtrSel(ldPtrSel), .ldPtrVal(ldPtrVal),
    .ldModEn(ldModEn), .ldModSel(ldModSel), .ldModVal(ldModVal),
    .accEn(accEn), .accSel(accSel), .accMode(accMode),
    .addrOut(addrOut)
  );

  // reference step, written from the requirements
  function automatic logic [7:0] refStep(logic [7:0] cur, logic [7:0] n, logic [2:0] md);
    int lim;
    lim = (n == 0) ? 256 : int'(n);
    case (md)
      3'd1: return 8'((int'(cur) + 1) % 256);
      3'd2: return 8'((int'(cur) + 255) % 256);
      3'd3: return (int'(cur) == lim - 1) ? 8'd0 : 8'((int'(cur) + 1) % 256);
      3'd4: return (cur == 8'd0) ? 8'(lim - 1) : cur - 8'd1;
      default: return cur;
    endcase
  endfunction

  task automatic checkVal(input logic [7:0] act, input logic [7:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: addrOut=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock cycle of stimulus, model updated at the edge
  task automatic cyc(input bit lp, input bit ps, input logic [7:0] pv,
                     input bit lm, input bit ms, input logic [7:0] mv,
                     input bit ae, input bit as, input logic [2:0] am);
    logic [7:0] nxt [2];
    @(negedge clk);
    ldPtrEn = lp; ldPtrSel = ps; ldPtrVal = pv;
    ldModEn = lm; ldModSel = ms; ldModVal = mv;
    accEn = ae; accSel = as; accMode = am;
    #1;
    checkVal(addrOut, mPtr[as], "R2 pre-modify address");
    @(posedge clk);
    for (int k = 0; k < 2; k++) nxt[k] = mPtr[k];
    if (ae) nxt[as] = refStep(mPtr[as], mMod[as], am);
    if (lp) nxt[ps] = pv;
    if (lm) mMod[ms] = mv;
    for (int k = 0; k < 2; k++) mPtr[k] = nxt[k];
  endtask

  // read a pointer through a hold access and compare to a constant
  task automatic peek(input bit sel, input logic [7:0] exp, input string req);
    @(negedge clk);
    ldPtrEn = 0; ldModEn = 0; accEn = 1; accSel = sel; accMode = 3'd0;
    #1;
    checkVal(addrOut, exp, req);
  endtask

  task automatic ldP(input bit s, input logic [7:0] v);
    cyc(1, s, v, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic ldM(input bit s, input logic [7:0] v);
    cyc(0, 0, 0, 1, s, v, 0, 0, 0);
  endtask

  task automatic acc(input bit s, input logic [2:0] m);
    cyc(0, 0, 0, 0, 0, 0, 1, s, m);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int k = 0; k < 2; k++) begin mPtr[k] = 0; mMod[k] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    peek(0, 8'd0, "R1 pointer0 reset");
    peek(1, 8'd0, "R1 pointer1 reset");

    // R3 and R4 full-range wrap
    ldP(0, 8'd255); acc(0, 3'd1); peek(0, 8'd0, "R3 255 up to 0");
    acc(0, 3'd2); peek(0, 8'd255, "R4 0 down to 255");
    ldP(1, 8'd7); acc(1, 3'd1); peek(1, 8'd8, "R3 plain increment");

    // R5 / R6 circular steps on pointer1, modulus 4
    ldM(1, 8'd4); ldP(1, 8'd3); acc(1, 3'd3); peek(1, 8'd0, "R5 N-1 up to 0");
    acc(1, 3'd3); peek(1, 8'd1, "R5 plain step inside ring");
    ldP(1, 8'd0); acc(1, 3'd4); peek(1, 8'd3, "R6 0 down to N-1");
    acc(1, 3'd4); peek(1, 8'd2, "R6 plain step inside ring");

    // R7 zero modulus on pointer0
    ldP(0, 8'd255); acc(0, 3'd3); peek(0, 8'd0, "R7 zero modulus up wrap");
    acc(0, 3'd4); peek(0, 8'd255, "R7 zero modulus down wrap");

    // R8 collisions
    ldP(0, 8'd10);
    cyc(1, 0, 8'd50, 0, 0, 0, 1, 0, 3'd1); peek(0, 8'd50, "R8 load beats step");
    cyc(1, 1, 8'd20, 0, 0, 0, 1, 0, 3'd2);
    peek(0, 8'd49, "R8 other pointer still steps");
    peek(1, 8'd20, "R8 other pointer loaded");

    // R9 holds
    acc(0, 3'd6); peek(0, 8'd49, "R9 unused code holds");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 3'd1); peek(0, 8'd49, "R9 accEn low holds");

    // R10 modulus timing
    ldM(0, 8'd3); ldP(0, 8'd2);
    cyc(0, 0, 0, 1, 0, 8'd8, 1, 0, 3'd3); peek(0, 8'd0, "R10 old modulus used");
    peek(0, 8'd0, "R10 modulus load leaves pointer");
    ldP(0, 8'd2); acc(0, 3'd3); peek(0, 8'd3, "R10 new modulus active");

    // random mix checked against the model
    for (int i = 0; i < 3000; i++) begin
      cyc(($urandom % 8) == 0, 1'($urandom), 8'($urandom % 20),
          ($urandom % 8) == 0, 1'($urandom), 8'($urandom % 17),
          ($urandom % 4) != 0, 1'($urandom), 3'($urandom));
    end
    peek(0, mPtr[0], "R2 final pointer0");
    peek(1, mPtr[1], "R2 final pointer1");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule